// File: doc/BRIEF.md
# Fractional Timer Tick Prescaler

This block turns a stream of source-clock enable pulses into a tick enable for a bank of free-running local timers. One of two enable sources is picked by a control bit. A 32-bit phase accumulator sets the tick rate. The tick rate equals the source rate times 2^31 divided by the programmed prescale value, so 0x80000000 gives one tick per source enable. Larger values slow the tick by a fractional ratio, with no drift over time.

Each tick is a one-cycle pulse. The same pulse advances a 64-bit timebase by one or by two, as chosen by a second control bit. Software programs the block through single-cycle register writes and reads two registers. The settings register is at offset 0x00 and the prescale register is at offset 0x08.

Top module: `frac_tick_prescaler`

## Requirements
- R1: After a synchronous active-low reset, the settings register reads 0, the prescale register reads 0x80000000, the timebase is 0 and tick is low.
- R2: A write to offset 0x00 or 0x08 stores all 32 bits, and a read of that offset returns them. A read of any other offset returns 0, and a write to any other offset changes neither register.
- R3: Settings bit 8 selects the enable source: 0 selects `ref_en` and 1 selects `alt_en`. Pulses on the unselected source produce no tick.
- R4: With prescale 0x80000000, every selected enable produces a tick in the next cycle.
- R5: With prescale P at or above 0x80000000, the k-th selected enable since the accumulator last restarted yields a tick exactly when floor(k*2^31/P) exceeds floor((k-1)*2^31/P).
- R6: A prescale of 0 produces no ticks, and the timebase holds its value.
- R7: A nonzero prescale below 0x80000000 saturates: every selected enable ticks, and the accumulator stays cleared.
- R8: The timebase changes only in the cycle that tick is high. It grows by 1 when settings bit 9 is 0 and by 2 when that bit is 1.
- R9: Any write to the prescale register restarts the accumulator at zero.
- R10: Tick is high only in a cycle that follows a selected enable, so an isolated enable gives a pulse exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | Enable pulse from the reference-clock source |
| alt_en | input | 1 | Enable pulse from the alternate source |
| reg_wr | input | 1 | Write strobe for the register interface |
| reg_addr | input | 8 | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick | output | 1 | One-cycle tick pulse |
| count | output | 64 | Timebase advanced on each tick |

## Verification
The accumulator is tried with several prescale values, and each one separates a different fault:
- The unity value shows whether the tick register delays the enable by one cycle.
- 0xC0000000 and 0xFFFFFFFF show whether the overflow comparison and the remainder kept after it are correct, because each gives a distinct tick pattern.
- Zero and a sub-unity value exercise the two guard paths.

Enables are sent both spaced out and back to back. They arrive on each source under each setting of the select bit. A prescale rewrite that falls between two enables shows whether the phase is restarted.

// File: rtl/frac_tick_pkg.sv
// Shared constants for the fractional tick prescaler: register offsets,
// settings bit positions, widths and reset values.
package frac_tick_pkg;
    localparam int REG_AW      = 8;
    localparam int DATA_W      = 32;
    localparam int COUNT_W     = 64;
    localparam int NUM_SRC     = 2;

    localparam logic [REG_AW-1:0] OFS_SETTINGS = 8'h00;
    localparam logic [REG_AW-1:0] OFS_PRESCALE = 8'h08;

    localparam int SRC_SEL_BIT = 8;
    localparam int STEP_BIT    = 9;

    localparam logic [DATA_W-1:0] SETTINGS_RST = '0;
    localparam logic [DATA_W-1:0] PRESCALE_RST = 32'h8000_0000;

    // Decoded view of the settings register used by the datapath.
    typedef struct packed {
        logic dbl_step;
        logic alt_src;
    } tick_cfg_t;
endpackage

// File: rtl/tick_cfg_regs.sv
// Register file for the prescaler: settings and prescale registers
// behind a single-cycle write strobe and a combinational read port.
// Assumes one shared address for reads and writes; unmapped offsets
// read as zero and ignore writes.
module tick_cfg_regs
    import frac_tick_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] settings_q,
    output logic [DW-1:0] prescale_q,
    output logic          prescale_wr
);
    logic hit_settings;
    logic hit_prescale;

    // Decode the offset once for both ports.
    always_comb begin
        hit_settings = (addr == OFS_SETTINGS);
        hit_prescale = (addr == OFS_PRESCALE);
    end

    // Settings register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                 settings_q <= SETTINGS_RST;
        else if (wr && hit_settings) settings_q <= wdata;
    end

    // Prescale register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                 prescale_q <= PRESCALE_RST;
        else if (wr && hit_prescale) prescale_q <= wdata;
    end

    // Restart request to the accumulator on any prescale write.
    always_comb prescale_wr = wr && hit_prescale;

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (hit_settings)      rdata = settings_q;
        else if (hit_prescale) rdata = prescale_q;
    end
endmodule

// File: rtl/tick_src_sel.sv
// Picks one of NUM enable sources by index. Assumes every source is
// already a single-cycle enable in this clock domain.
module tick_src_sel #(
    parameter int NUM = 2,
    localparam int SW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0] src_en,
    input  logic [SW-1:0]  sel,
    output logic           en_out
);
    logic [NUM-1:0] gated;

    // Gate each source with its own select match.
    for (genvar i = 0; i < NUM; i++) begin : g_gate
        always_comb gated[i] = src_en[i] && (sel == SW'(i));
    end

    // Merge the gated sources.
    always_comb en_out = |gated;
endmodule

// File: rtl/tick_phase_acc.sv
// Fractional phase accumulator. Each enable adds one unit (2^(W-1)).
// A tick is issued when the sum reaches the prescale value, which is
// then subtracted. Zero disables ticking, and nonzero values below
// the unit saturate to one tick per enable. A restart clears the
// phase and takes priority over the update in the same cycle.
module tick_phase_acc #(
    parameter int W = 32,
    localparam int SUM_W = W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic [W-1:0] prescale,
    input  logic         restart,
    output logic         hit,
    output logic         tick_q
);
    localparam logic [SUM_W-1:0] UNIT = SUM_W'(1) << (W - 1);

    logic [W-1:0]     phase_q;
    logic [W-1:0]     phase_d;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wide_p;
    logic [SUM_W-1:0] rem;

    // Next phase and the overflow decision.
    always_comb begin
        wide_p  = {1'b0, prescale};
        sum     = {1'b0, phase_q} + UNIT;
        rem     = sum - wide_p;
        hit     = 1'b0;
        phase_d = phase_q;
        if (step_en && (prescale != '0)) begin
            if (wide_p < UNIT) begin
                hit     = 1'b1;
                phase_d = '0;
            end else if (sum >= wide_p) begin
                hit     = 1'b1;
                phase_d = rem[W-1:0];
            end else begin
                phase_d = sum[W-1:0];
            end
        end
        if (restart) phase_d = '0;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // Registered tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= hit;
    end
endmodule

// File: rtl/tick_timebase.sv
// Free-running timebase that advances by 1 or 2 on each tick.
// Assumes the advance request is the combinational tick decision,
// so the count changes on the same edge that raises the tick output.
module tick_timebase #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          dbl,
    output logic [CW-1:0] count_q
);
    logic [CW-1:0] incr;

    // Step size from the settings bit.
    always_comb incr = dbl ? CW'(2) : CW'(1);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)   count_q <= '0;
        else if (adv) count_q <= count_q + incr;
    end
endmodule

// File: rtl/frac_tick_prescaler.sv
// Top of the fractional tick prescaler. Connects the register file,
// the source selector, the phase accumulator and the timebase. Assumes
// both enable inputs are already synchronous to clk.
module frac_tick_prescaler
    import frac_tick_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_en,
    input  logic                 alt_en,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 tick,
    output logic [COUNT_W-1:0]   count
);
    logic [DATA_W-1:0]  ctrl_q;
    logic [DATA_W-1:0]  presc_q;
    logic               presc_wr;
    tick_cfg_t          cfg;
    logic [NUM_SRC-1:0] srcs;
    logic               sel_en;
    logic               hit;

    // Decode the settings bits the datapath uses.
    always_comb begin
        cfg.alt_src  = ctrl_q[SRC_SEL_BIT];
        cfg.dbl_step = ctrl_q[STEP_BIT];
        srcs         = {alt_en, ref_en};
    end

    tick_cfg_regs #(.AW(REG_AW), .DW(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .settings_q  (ctrl_q),
        .prescale_q  (presc_q),
        .prescale_wr (presc_wr)
    );

    tick_src_sel #(.NUM(NUM_SRC)) u_sel (
        .src_en (srcs),
        .sel    (cfg.alt_src),
        .en_out (sel_en)
    );

    tick_phase_acc #(.W(DATA_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (sel_en),
        .prescale (presc_q),
        .restart  (presc_wr),
        .hit      (hit),
        .tick_q   (tick)
    );

    tick_timebase #(.CW(COUNT_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (hit),
        .dbl     (cfg.dbl_step),
        .count_q (count)
    );
endmodule

// File: rtl/frac_tick_prescaler_chk.sv
// Property checker for the fractional tick prescaler, bound to the top.
module frac_tick_prescaler_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ref_en,
    input logic        alt_en,
    input logic [31:0] ctrl_q,
    input logic [31:0] presc_q,
    input logic        tick,
    input logic [63:0] count
);
    logic armed;
    logic src_pick;

    // Arms the properties one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // The enable seen by the selected source.
    always_comb src_pick = ctrl_q[8] ? alt_en : ref_en;

    AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        tick |-> $past(src_pick)); // R10

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !tick |-> $stable(count)); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        tick |-> (count == $past(count) + ($past(ctrl_q[9]) ? 64'd2 : 64'd1))); // R8

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(presc_q) == 32'd0) |-> !tick); // R6

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(src_pick) && $past(presc_q) != 32'd0 && $past(presc_q) <= 32'h8000_0000)
        |-> tick); // R4
endmodule

bind frac_tick_prescaler frac_tick_prescaler_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_en  (ref_en),
    .alt_en  (alt_en),
    .ctrl_q  (ctrl_q),
    .presc_q (presc_q),
    .tick    (tick),
    .count   (count)
);

// File: tb/frac_tick_prescaler_test.sv
module frac_tick_prescaler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b0;
    logic        alt_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick;
    logic [63:0] count;

    int checks = 0;
    int failures = 0;
    int ticks_seen = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_presc = 32'h8000_0000;
    longint      m_acc = 0;
    logic [63:0] m_count = '0;
    logic        m_tick = 1'b0;

    frac_tick_prescaler uut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .alt_en(alt_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tick(tick), .count(count)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: one step per clock from the sampled inputs.
    always @(posedge clk) begin
        logic en;
        logic hit;
        longint unit;
        unit = 64'h8000_0000;
        if (!rst_n) begin
            m_ctrl = '0; m_presc = 32'h8000_0000; m_acc = 0; m_count = '0; m_tick = 1'b0;
        end else begin
            en  = m_ctrl[8] ? alt_en : ref_en;
            hit = 1'b0;
            if (en && m_presc != 0) begin
                if (longint'(m_presc) < unit) begin
                    hit = 1'b1; m_acc = 0;
                end else if (m_acc + unit >= longint'(m_presc)) begin
                    hit = 1'b1; m_acc = m_acc + unit - longint'(m_presc);
                end else begin
                    m_acc = m_acc + unit;
                end
            end
            if (hit) m_count = m_count + (m_ctrl[9] ? 64'd2 : 64'd1);
            if (reg_wr && reg_addr == 8'h00) m_ctrl = reg_wdata;
            if (reg_wr && reg_addr == 8'h08) begin m_presc = reg_wdata; m_acc = 0; end
            m_tick = hit;
        end
    end

    // Per-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] exp_rd;
            exp_rd = (reg_addr == 8'h00) ? m_ctrl : (reg_addr == 8'h08) ? m_presc : 32'h0;
            check("R5 R4 R10 tick", {63'd0, tick}, {63'd0, m_tick});
            check("R8 count", count, m_count);
            check("R2 rdata", {32'd0, reg_rdata}, {32'd0, exp_rd});
            if (tick) ticks_seen++;
        end
    end

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic pulses(input bit use_alt, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (use_alt) alt_en = 1'b1; else ref_en = 1'b1;
            if (gap > 0) begin
                @(posedge clk); #1;
                alt_en = 1'b0; ref_en = 1'b0;
                repeat (gap - 1) @(posedge clk);
            end
        end
        @(posedge clk); #1;
        alt_en = 1'b0; ref_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_at(input logic [7:0] a);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] c0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tick", {63'd0, tick}, 64'd0);
        check("R1 count", count, 64'd0);
        read_at(8'h00); check("R1 settings", {32'd0, reg_rdata}, 64'd0);
        read_at(8'h08); check("R1 prescale", {32'd0, reg_rdata}, 64'h8000_0000);

        // R2 readback and unmapped offsets
        write_reg(8'h00, 32'h1234_5078);
        read_at(8'h00); check("R2 settings readback", {32'd0, reg_rdata}, 64'h1234_5078);
        write_reg(8'h04, 32'hDEAD_BEEF);
        read_at(8'h04); check("R2 unmapped reads zero", {32'd0, reg_rdata}, 64'd0);
        read_at(8'h00); check("R2 settings untouched", {32'd0, reg_rdata}, 64'h1234_5078);
        read_at(8'h08); check("R2 prescale untouched", {32'd0, reg_rdata}, 64'h8000_0000);
        write_reg(8'h00, 32'h0);

        // R4 unity ratio
        ticks_seen = 0; c0 = count;
        pulses(1'b0, 5, 2);
        check("R4 ticks at unity", 64'(ticks_seen), 64'd5);
        check("R4 count at unity", count - c0, 64'd5);

        // R3 source selection
        ticks_seen = 0;
        pulses(1'b1, 4, 2);
        check("R3 alt ignored when bit8 clear", 64'(ticks_seen), 64'd0);
        write_reg(8'h00, 32'h100);
        ticks_seen = 0;
        pulses(1'b0, 3, 2);
        check("R3 ref ignored when bit8 set", 64'(ticks_seen), 64'd0);
        ticks_seen = 0;
        pulses(1'b1, 4, 1);
        check("R3 alt used when bit8 set", 64'(ticks_seen), 64'd4);
        write_reg(8'h00, 32'h0);

        // R5 fractional ratios
        write_reg(8'h08, 32'hC000_0000);
        ticks_seen = 0;
        pulses(1'b0, 12, 1);
        check("R5 ratio 1.5", 64'(ticks_seen), 64'd8);
        write_reg(8'h08, 32'hFFFF_FFFF);
        ticks_seen = 0;
        pulses(1'b0, 10, 0);
        check("R5 ratio near 2", 64'(ticks_seen), 64'd5);

        // R6 zero prescale
        write_reg(8'h08, 32'h0);
        ticks_seen = 0; c0 = count;
        pulses(1'b0, 6, 1);
        check("R6 no ticks", 64'(ticks_seen), 64'd0);
        check("R6 count held", count, c0);

        // R7 saturation below unity
        write_reg(8'h08, 32'h4000_0000);
        ticks_seen = 0;
        pulses(1'b0, 6, 0);
        check("R7 every enable ticks", 64'(ticks_seen), 64'd6);

        // R8 double step
        write_reg(8'h08, 32'h8000_0000);
        write_reg(8'h00, 32'h200);
        ticks_seen = 0; c0 = count;
        pulses(1'b0, 4, 2);
        check("R8 ticks", 64'(ticks_seen), 64'd4);
        check("R8 count by two", count - c0, 64'd8);
        write_reg(8'h00, 32'h0);

        // R9 prescale write restarts the phase
        write_reg(8'h08, 32'hC000_0000);
        ticks_seen = 0;
        pulses(1'b0, 1, 1);
        write_reg(8'h08, 32'hC000_0000);
        pulses(1'b0, 1, 1);
        check("R9 restart suppresses tick", 64'(ticks_seen), 64'd0);
        pulses(1'b0, 1, 1);
        check("R9 second enable after restart ticks", 64'(ticks_seen), 64'd1);

        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule